// File: doc/BRIEF.md
# Secure/Non-secure Aliasing Address Decoder

This block turns a 32-bit request address into a single target select for a small secure microcontroller subsystem. It also produces the address offset inside that target, or an error flag when nothing is mapped at the address. The address space is split into 256 MB windows selected by the top four address bits. Every odd window among windows 1, 3 and 5 mirrors the even window just below it, so each memory and peripheral can be reached at a non-secure address and again at a secure address. A few control devices exist only in the secure peripheral window. They are mapped directly there and override the mirror. The two register views of the security controller are separate targets.

A request is offered with `req_valid`, together with `req_addr` and `req_write`. The decoder never applies back-pressure: `req_ready` is always high, and every valid beat is accepted at the clock edge where it is presented. The decode result appears on the registered `rsp_*` outputs one clock later. `rsp_valid` pulses for one cycle to mark each new result. The result stays unchanged until the next accepted request. The consumer has no ready signal, so it must take each result while `rsp_valid` is high or read the held value later.

Top module: `sns_addr_decoder`

## Requirements
- R1: Window 0x0 (0x0000_0000–0x0FFF_FFFF) selects board memory (select bit 0) with offset `addr[27:0]`. Window 0x1 mirrors it with the same select and the same offset.
- R2: A 32 KB RAM (select bit 1) decodes at 0x2000_0000–0x2000_7FFF with offset `addr[14:0]`, and through the mirror at 0x3000_0000–0x3000_7FFF. Any other address in windows 0x2 or 0x3 is unmapped.
- R3: These 4 KB peripheral slots decode with offset `addr[11:0]`, both at the listed base and at base + 0x1000_0000:
  - timer A (bit 2) at 0x4000_0000
  - timer B (bit 3) at 0x4000_1000
  - dual timer (bit 4) at 0x4000_2000
  - system info (bit 5) at 0x4002_0000
  - always-on timer (bit 6) at 0x4002_F000
  - non-secure watchdog (bit 8) at 0x4008_1000
- R4: These secure-only 4 KB slots exist only in window 0x5 and take priority over the mirror there, with offset `addr[11:0]`:
  - secure watchdog (bit 10) at 0x5008_1000
  - system control (bit 11) at 0x5002_1000
  - always-on watchdog (bit 12) at 0x5002_E000
  - RAM protection controller (bit 13) at 0x5008_3000

  The same offsets in window 0x4 are unmapped.
- R5: The security controller has two distinct selects: its non-secure view (bit 7) at 0x4008_0000 and its secure view (bit 9) at 0x5008_0000. The secure address never produces the non-secure select.
- R6: An address that matches no slot, directly or through a mirror, sets `rsp_err` with `rsp_sel` = 0 and `rsp_offset` = 0. Every non-error result has exactly one select bit set.
- R7: A request accepted at a clock edge updates `rsp_sel`, `rsp_offset` and `rsp_err` at that same edge and raises `rsp_valid` for exactly that one cycle. The outputs do not change before that edge.
- R8: While `req_valid` is low, the registered results stay unchanged and `rsp_valid` stays low, whatever `req_addr` and `req_write` do.
- R9: A synchronous reset clears `rsp_sel`, `rsp_offset`, `rsp_err`, `rsp_write` and `rsp_valid` to zero.
- R10: `req_ready` is always 1, and `rsp_write` carries the `req_write` value of the accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request address is valid this cycle |
| req_ready | output | 1 | Always high; the decoder never stalls |
| req_addr | input | 32 | Request address |
| req_write | input | 1 | Request is a write |
| rsp_valid | output | 1 | One-cycle pulse: a new decode result is on the outputs |
| rsp_sel | output | 14 | One-hot target select (bit map in R1–R5) |
| rsp_offset | output | 28 | Offset inside the selected target |
| rsp_err | output | 1 | No target is mapped at the address |
| rsp_write | output | 1 | Write flag of the decoded request |

## Verification
The checker takes for granted that reset is asserted at the first clock edge. It also assumes `req_valid` is a clean level sampled at the rising edge, so the address seen one cycle before `rsp_valid` is the address that was decoded. The bench holds reset from time zero and changes inputs only on the falling edge. While `req_valid` is low it deliberately drives unmapped and secure-only addresses, so the hold property is tested against addresses that would change the result if they were decoded.

// File: rtl/sns_dec_pkg.sv
package sns_dec_pkg;
  localparam int ADDR_W  = 32;
  localparam int WIN_W   = 4;
  localparam int OFF_W   = ADDR_W - WIN_W;
  localparam int NUM_TGT = 14;

  localparam int T_BOARD   = 0;
  localparam int T_SRAM    = 1;
  localparam int T_TMR_A   = 2;
  localparam int T_TMR_B   = 3;
  localparam int T_DUALTMR = 4;
  localparam int T_SYSINFO = 5;
  localparam int T_AONTMR  = 6;
  localparam int T_SCU_NS  = 7;
  localparam int T_WDOG_NS = 8;
  localparam int T_SCU_S   = 9;
  localparam int T_WDOG_S  = 10;
  localparam int T_SYSCTRL = 11;
  localparam int T_AONWDOG = 12;
  localparam int T_RAMPROT = 13;

  function automatic logic [ADDR_W-1:0] tgt_base(input int idx);
    case (idx)
      T_BOARD:   return 32'h0000_0000;
      T_SRAM:    return 32'h2000_0000;
      T_TMR_A:   return 32'h4000_0000;
      T_TMR_B:   return 32'h4000_1000;
      T_DUALTMR: return 32'h4000_2000;
      T_SYSINFO: return 32'h4002_0000;
      T_AONTMR:  return 32'h4002_F000;
      T_SCU_NS:  return 32'h4008_0000;
      T_WDOG_NS: return 32'h4008_1000;
      T_SCU_S:   return 32'h5008_0000;
      T_WDOG_S:  return 32'h5008_1000;
      T_SYSCTRL: return 32'h5002_1000;
      T_AONWDOG: return 32'h5002_E000;
      default:   return 32'h5008_3000;
    endcase
  endfunction

  // log2 of the span of each target
  function automatic int tgt_span(input int idx);
    case (idx)
      T_BOARD: return OFF_W;
      T_SRAM:  return 15;
      default: return 12;
    endcase
  endfunction

  function automatic logic [OFF_W-1:0] span_mask(input int idx);
    logic [OFF_W:0] one;
    one = 1;
    return OFF_W'((one << tgt_span(idx)) - 1);
  endfunction
endpackage

// File: rtl/sns_alias_fold.sv
module sns_alias_fold #(
  parameter int ADDR_W = 32,
  parameter int WIN_W  = 4,
  parameter logic [(1<<WIN_W)-1:0] MIRROR_WINDOWS = 16'h002A
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] fold_addr,
  output logic              mirror_ok
);
  localparam int LOW_W = ADDR_W - WIN_W;
  logic [WIN_W-1:0] win;

  assign win       = addr[ADDR_W-1 -: WIN_W];
  assign mirror_ok = MIRROR_WINDOWS[win];
  assign fold_addr = {win[WIN_W-1:1], 1'b0, addr[LOW_W-1:0]};
endmodule

// File: rtl/sns_slot_match.sv
module sns_slot_match
  import sns_dec_pkg::*;
(
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_TGT-1:0] hit
);
  for (genvar i = 0; i < NUM_TGT; i++) begin : g_slot
    localparam logic [ADDR_W-1:0] BASE = tgt_base(i);
    localparam int SP = tgt_span(i);
    assign hit[i] = (addr[ADDR_W-1:SP] == BASE[ADDR_W-1:SP]);
  end
endmodule

// File: rtl/sns_pick.sv
module sns_pick
  import sns_dec_pkg::*;
(
  input  logic [NUM_TGT-1:0] direct_hit,
  input  logic [NUM_TGT-1:0] mirror_hit,
  input  logic               mirror_ok,
  input  logic [OFF_W-1:0]   addr_lo,
  output logic [NUM_TGT-1:0] sel,
  output logic [OFF_W-1:0]   offset,
  output logic               err
);
  always_comb begin
    if (|direct_hit)    sel = direct_hit;
    else if (mirror_ok) sel = mirror_hit;
    else                sel = '0;
    err    = ~|sel;
    offset = '0;
    for (int i = 0; i < NUM_TGT; i++) begin
      if (sel[i]) offset = offset | (addr_lo & span_mask(i));
    end
  end
endmodule

// File: rtl/sns_addr_decoder.sv
module sns_addr_decoder
  import sns_dec_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic               req_write,
  output logic               rsp_valid,
  output logic [NUM_TGT-1:0] rsp_sel,
  output logic [OFF_W-1:0]   rsp_offset,
  output logic               rsp_err,
  output logic               rsp_write
);
  logic [ADDR_W-1:0]  fold_addr;
  logic               mirror_ok;
  logic [NUM_TGT-1:0] direct_hit, mirror_hit, sel_c;
  logic [OFF_W-1:0]   off_c;
  logic               err_c;

  assign req_ready = 1'b1;

  sns_alias_fold #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_fold (
    .addr(req_addr), .fold_addr(fold_addr), .mirror_ok(mirror_ok)
  );

  sns_slot_match u_direct (.addr(req_addr),  .hit(direct_hit));
  sns_slot_match u_mirror (.addr(fold_addr), .hit(mirror_hit));

  sns_pick u_pick (
    .direct_hit(direct_hit), .mirror_hit(mirror_hit), .mirror_ok(mirror_ok),
    .addr_lo(req_addr[OFF_W-1:0]), .sel(sel_c), .offset(off_c), .err(err_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_sel    <= '0;
      rsp_offset <= '0;
      rsp_err    <= 1'b0;
      rsp_write  <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_sel    <= sel_c;
        rsp_offset <= off_c;
        rsp_err    <= err_c;
        rsp_write  <= req_write;
      end
    end
  end
endmodule

// File: rtl/sns_decoder_checker.sv
module sns_decoder_checker
  import sns_dec_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic [ADDR_W-1:0]  req_addr,
  input logic               req_write,
  input logic               rsp_valid,
  input logic [NUM_TGT-1:0] rsp_sel,
  input logic [OFF_W-1:0]   rsp_offset,
  input logic               rsp_err,
  input logic               rsp_write
);
  AST_LOW_MIRROR: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && $past(req_addr[ADDR_W-1 -: WIN_W]) == 4'h1 |-> rsp_sel == 14'h0001 && !rsp_err); // R1

  AST_RAM_OFFSET: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_sel[T_SRAM] |-> rsp_offset[OFF_W-1:15] == '0); // R2

  AST_SECURE_ONLY: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && (|rsp_sel[T_RAMPROT:T_SCU_S]) |-> $past(req_addr[ADDR_W-1 -: WIN_W]) == 4'h5); // R4

  AST_SCU_SPLIT: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_sel[T_SCU_NS] |-> $past(req_addr[ADDR_W-1 -: WIN_W]) == 4'h4); // R5

  AST_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_err ? (rsp_sel == '0 && rsp_offset == '0) : ($countones(rsp_sel) == 1))); // R6

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R7

  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid && $stable(rsp_sel) && $stable(rsp_offset) && $stable(rsp_err)); // R8

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> !rsp_valid && rsp_sel == '0 && rsp_offset == '0 && !rsp_err && !rsp_write); // R9

  AST_WRITE_FLAG: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_write == $past(req_write)); // R10
endmodule

bind sns_addr_decoder sns_decoder_checker u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
  .req_write(req_write), .rsp_valid(rsp_valid), .rsp_sel(rsp_sel),
  .rsp_offset(rsp_offset), .rsp_err(rsp_err), .rsp_write(rsp_write)
);

// File: tb/sim_sns_addr_decoder.sv
`timescale 1ns/1ps
module sim_sns_addr_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic [13:0] rsp_sel;
  logic [27:0] rsp_offset;
  logic        rsp_err;
  logic        rsp_write;
  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sns_addr_decoder u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .rsp_valid(rsp_valid),
    .rsp_sel(rsp_sel), .rsp_offset(rsp_offset), .rsp_err(rsp_err),
    .rsp_write(rsp_write)
  );

  localparam int NV = 28;
  localparam logic [31:0] VA [NV] = '{
    32'h0000_0010, 32'h1234_5678, 32'h0FFF_FFFC, 32'h2000_7FFC, 32'h2000_8000,
    32'h3000_0004, 32'h3000_8000, 32'h4000_0008, 32'h4000_1ABC, 32'h5000_2010,
    32'h4002_0040, 32'h5002_0040, 32'h4002_F004, 32'h5002_F004, 32'h4008_0020,
    32'h5008_0020, 32'h4008_1008, 32'h5008_1008, 32'h5002_1000, 32'h4002_1000,
    32'h5002_E0FC, 32'h4002_E000, 32'h5008_3FFC, 32'h4008_3000, 32'h4000_3000,
    32'h6000_0000, 32'hF000_0000, 32'h5000_1FFF};
  localparam logic [13:0] VS [NV] = '{
    14'h0001, 14'h0001, 14'h0001, 14'h0002, 14'h0000,
    14'h0002, 14'h0000, 14'h0004, 14'h0008, 14'h0010,
    14'h0020, 14'h0020, 14'h0040, 14'h0040, 14'h0080,
    14'h0200, 14'h0100, 14'h0400, 14'h0800, 14'h0000,
    14'h1000, 14'h0000, 14'h2000, 14'h0000, 14'h0000,
    14'h0000, 14'h0000, 14'h0008};
  localparam logic [27:0] VO [NV] = '{
    28'h0000010, 28'h2345678, 28'hFFFFFFC, 28'h7FFC, 28'h0,
    28'h4, 28'h0, 28'h008, 28'hABC, 28'h010,
    28'h040, 28'h040, 28'h004, 28'h004, 28'h020,
    28'h020, 28'h008, 28'h008, 28'h000, 28'h0,
    28'h0FC, 28'h0, 28'hFFC, 28'h0, 28'h0,
    28'h0, 28'h0, 28'hFFF};

  function automatic string tag_of(input logic [13:0] s, input logic [31:0] a);
    if (s == 0) return (a[31:28] == 4'h4 || a[31:28] == 4'h5) ? "R4/R6" : "R2/R6";
    if (s[0]) return "R1";
    if (s[1]) return "R2";
    if (s[7] || s[9]) return "R5";
    if (|s[13:10]) return "R4";
    return "R3";
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] a, input logic w);
    @(negedge clk);
    req_addr = a; req_write = w; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 sel", 32'(rsp_sel), 0);
    chk("R9 err/valid/write", {29'b0, rsp_err, rsp_valid, rsp_write}, 0);
    chk("R10 ready", 32'(req_ready), 1);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      issue(VA[i], i[0]);
      chk({tag_of(VS[i], VA[i]), " sel"}, 32'(rsp_sel), 32'(VS[i]));
      chk({tag_of(VS[i], VA[i]), " offset"}, 32'(rsp_offset), 32'(VO[i]));
      chk("R6 err", 32'(rsp_err), 32'(VS[i] == 0));
      chk("R7 valid pulse", 32'(rsp_valid), 1);
      chk("R10 write", 32'(rsp_write), 32'(i[0]));
    end

    // R8 hold: valid low, address wiggles over decoding addresses
    issue(32'h4000_1004, 1'b1);
    @(negedge clk);
    req_addr = 32'h5008_3000; req_write = 1'b0;
    @(negedge clk);
    req_addr = 32'h7000_0000;
    @(negedge clk);
    chk("R8 sel", 32'(rsp_sel), 32'h0008);
    chk("R8 offset", 32'(rsp_offset), 32'h004);
    chk("R8 err", 32'(rsp_err), 0);
    chk("R8 valid low", 32'(rsp_valid), 0);
    chk("R8 write", 32'(rsp_write), 1);

    // R7: no change before the capturing edge
    @(negedge clk);
    req_addr = 32'h5002_E010; req_valid = 1'b1;
    #1;
    chk("R7 early sel", 32'(rsp_sel), 32'h0008);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7 late sel", 32'(rsp_sel), 32'h1000);
    @(negedge clk);
    chk("R7 single pulse", 32'(rsp_valid), 0);

    // R9 reset mid-run
    rst = 1'b1;
    @(negedge clk);
    chk("R9 mid sel", 32'(rsp_sel), 0);
    chk("R9 mid offset", 32'(rsp_offset), 0);
    rst = 1'b0;
    // R6 after reset, error result
    issue(32'h8000_0000, 1'b0);
    chk("R6 err after reset", {30'b0, rsp_err, rsp_valid}, 32'h3);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nerr);
    $finish;
  end
endmodule